// File: doc/BRIEF.md
# Predicate-Setting Compare Unit

This block evaluates one integer test per operation and converts the single-bit outcome into writes for two 1-bit predicate targets. The test is either a relation between two operands or the state of one selected bit of the first operand. The second operand is either a register value or a sign-extended short immediate. A width flag chooses a full 64-bit test or a test on the low 32 bits only.

A 3-bit rule selector, combined with a qualifying predicate, decides for each target whether it is written and with which value. Each target has its own write enable, so a predicate file downstream can leave a target untouched. All results are registered: they appear one clock after the request, marked by a valid strobe.

Top module: `predCmpUnit`

## Requirements
- R1: Results appear exactly one clock after an accepted request (`inValid` high at a rising edge). `outValid` is high in that cycle only. In any cycle where `outValid` is low, both write enables are low.
- R2: Relation codes on `relCode` are: 0 equal, 1 not equal, 2 signed less-than, 3 signed less-or-equal, 4 signed greater-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned less-or-equal, 8 unsigned greater-than, 9 unsigned greater-or-equal. With `narrowMode`=0 they compare all 64 bits. Operand A is the left-hand side.
- R3: With `narrowMode`=1, only bits 31:0 of each operand take part. Signed relations treat bit 31 as the sign. The upper 32 bits have no effect on the outcome.
- R4: With `useImm`=1, operand B is the 8-bit `immVal` sign-extended to 64 bits, and `srcB` is ignored.
- R5: With `bitTest`=1, the outcome is `srcA[bitPos]` (bit 0 is the least significant bit). `relCode` and `narrowMode` have no effect on it.
- R6: With `bitTest`=0, a `relCode` of 10 to 15 produces no write on either target.
- R7: Rule codes on `cmpType` are: 0 normal, 1 unconditional, 2 and, 3 and-complement, 4 or, 5 or-complement, 6 or/and-complement, 7 and/or-complement. For rules 0 and 1 with `qualPred`=1, target 1 is written with the outcome and target 2 with its inverse. Rule 0 with `qualPred`=0 writes nothing.
- R8: Rule 1 with `qualPred`=0 writes 0 to both targets, whatever the outcome.
- R9: Rule 2 writes 0 to both targets when `qualPred`=1 and the outcome is 0. Rule 3 writes 0 to both when `qualPred`=1 and the outcome is 1. In all other cases these rules write nothing.
- R10: Rule 4 writes 1 to both targets when `qualPred`=1 and the outcome is 1. Rule 5 writes 1 to both when `qualPred`=1 and the outcome is 0. In all other cases these rules write nothing.
- R11: Rule 6 writes 1 to target 1 and 0 to target 2 when `qualPred`=1 and the outcome is 1. Rule 7 writes 0 to target 1 and 1 to target 2 when `qualPred`=1 and the outcome is 0. In all other cases these rules write nothing.
- R12: While `rstN` is low, `outValid` and both write enables are held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| srcA | input | 64 | Operand A, also the bit-test source |
| srcB | input | 64 | Register operand B |
| immVal | input | 8 | Immediate operand, sign-extended |
| useImm | input | 1 | Select the immediate as operand B |
| narrowMode | input | 1 | Compare bits 31:0 only |
| bitTest | input | 1 | Take the outcome from one bit of operand A |
| bitPos | input | 6 | Bit index for the bit test |
| relCode | input | 4 | Relation code |
| cmpType | input | 3 | Write rule code |
| qualPred | input | 1 | Qualifying predicate |
| outValid | output | 1 | Result strobe |
| tgt1WrEn | output | 1 | Target 1 write enable |
| tgt1Val | output | 1 | Target 1 write value (don't-care when not enabled) |
| tgt2WrEn | output | 1 | Target 2 write enable |
| tgt2Val | output | 1 | Target 2 write value (don't-care when not enabled) |

## Verification
Two decisions can land in the same cycle. The first is the legality screen on the relation code. The second is the unconditional rule's forced-zero write, which needs no outcome at all. The sweep drives every illegal code together with rule 1 and `qualPred`=0, and expects no enables: legality must win. It also drives illegal codes with `bitTest`=1, where the code must be ignored and the tested bit must produce normal writes. Every request is judged in the following cycle against an arithmetic model of the outcome and the rule table.

// File: rtl/predCmpPkg.sv
package predCmpPkg;

  localparam logic [2:0] CT_NORMAL    = 3'd0;
  localparam logic [2:0] CT_UNCOND    = 3'd1;
  localparam logic [2:0] CT_AND       = 3'd2;
  localparam logic [2:0] CT_ANDCM     = 3'd3;
  localparam logic [2:0] CT_OR        = 3'd4;
  localparam logic [2:0] CT_ORCM      = 3'd5;
  localparam logic [2:0] CT_OR_ANDCM  = 3'd6;
  localparam logic [2:0] CT_AND_ORCM  = 3'd7;

  localparam logic [3:0] REL_EQ  = 4'd0;
  localparam logic [3:0] REL_NE  = 4'd1;
  localparam logic [3:0] REL_LT  = 4'd2;
  localparam logic [3:0] REL_LE  = 4'd3;
  localparam logic [3:0] REL_GT  = 4'd4;
  localparam logic [3:0] REL_GE  = 4'd5;
  localparam logic [3:0] REL_LTU = 4'd6;
  localparam logic [3:0] REL_LEU = 4'd7;
  localparam logic [3:0] REL_GTU = 4'd8;
  localparam logic [3:0] REL_GEU = 4'd9;
  localparam logic [3:0] REL_MAX = REL_GEU;

  localparam int NUM_TGT = 2;

  // Strobes from control to datapath: relation shaping plus, per target,
  // the write enable and value to use for each outcome polarity.
  typedef struct packed {
    logic                opValid;
    logic                useBit;
    logic                selEq;
    logic                selUns;
    logic                swap;
    logic                invert;
    logic [NUM_TGT-1:0]  wrOnTrue;
    logic [NUM_TGT-1:0]  wrOnFalse;
    logic [NUM_TGT-1:0]  valOnTrue;
    logic [NUM_TGT-1:0]  valOnFalse;
  } ctrlStrobes_t;

endpackage

// File: rtl/predCmpCtrl.sv
module predCmpCtrl
  import predCmpPkg::*;
(
  input  logic         inValid,
  input  logic         bitTest,
  input  logic [3:0]   relCode,
  input  logic [2:0]   cmpType,
  input  logic         qualPred,
  output ctrlStrobes_t ctrl
);

  logic legal;

  always_comb begin
    ctrl = '0;
    ctrl.opValid = inValid;
    ctrl.useBit  = bitTest;
    legal = bitTest || (relCode <= REL_MAX);

    case (relCode)
      REL_EQ:  ctrl.selEq = 1'b1;
      REL_NE:  begin ctrl.selEq = 1'b1; ctrl.invert = 1'b1; end
      REL_LT:  ;
      REL_LE:  begin ctrl.swap = 1'b1; ctrl.invert = 1'b1; end
      REL_GT:  ctrl.swap = 1'b1;
      REL_GE:  ctrl.invert = 1'b1;
      REL_LTU: ctrl.selUns = 1'b1;
      REL_LEU: begin ctrl.selUns = 1'b1; ctrl.swap = 1'b1; ctrl.invert = 1'b1; end
      REL_GTU: begin ctrl.selUns = 1'b1; ctrl.swap = 1'b1; end
      REL_GEU: begin ctrl.selUns = 1'b1; ctrl.invert = 1'b1; end
      default: ;
    endcase

    if (inValid && legal) begin
      if (qualPred) begin
        case (cmpType)
          CT_NORMAL, CT_UNCOND: begin
            ctrl.wrOnTrue  = 2'b11; ctrl.valOnTrue  = 2'b01;
            ctrl.wrOnFalse = 2'b11; ctrl.valOnFalse = 2'b10;
          end
          CT_AND:      begin ctrl.wrOnFalse = 2'b11; ctrl.valOnFalse = 2'b00; end
          CT_ANDCM:    begin ctrl.wrOnTrue  = 2'b11; ctrl.valOnTrue  = 2'b00; end
          CT_OR:       begin ctrl.wrOnTrue  = 2'b11; ctrl.valOnTrue  = 2'b11; end
          CT_ORCM:     begin ctrl.wrOnFalse = 2'b11; ctrl.valOnFalse = 2'b11; end
          CT_OR_ANDCM: begin ctrl.wrOnTrue  = 2'b11; ctrl.valOnTrue  = 2'b01; end
          CT_AND_ORCM: begin ctrl.wrOnFalse = 2'b11; ctrl.valOnFalse = 2'b10; end
          default: ;
        endcase
      end else if (cmpType == CT_UNCOND) begin
        ctrl.wrOnTrue  = 2'b11; ctrl.valOnTrue  = 2'b00;
        ctrl.wrOnFalse = 2'b11; ctrl.valOnFalse = 2'b00;
      end
    end
  end

endmodule

// File: rtl/predCmpDatapath.sv
module predCmpDatapath
  import predCmpPkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 8,
  localparam int POS_W   = $clog2(DATA_W),
  localparam int HI_W    = DATA_W - NARROW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        ctrl,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W-1:0]   srcB,
  input  logic [IMM_W-1:0]    immVal,
  input  logic                useImm,
  input  logic                narrowMode,
  input  logic [POS_W-1:0]    bitPos,
  output logic                outValid,
  output logic [NUM_TGT-1:0]  tgtWrEn,
  output logic [NUM_TGT-1:0]  tgtVal
);

  logic [DATA_W-1:0]  opB;
  logic [DATA_W-1:0]  sA, sB, uA, uB;
  logic [DATA_W-1:0]  lhsS, rhsS, lhsU, rhsU;
  logic               isEq, ltRaw, relOut, outcome;
  logic [NUM_TGT-1:0] nextEn, nextVal;

  always_comb begin
    opB = useImm ? {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal} : srcB;
    if (narrowMode) begin
      sA = {{HI_W{srcA[NARROW_W-1]}}, srcA[NARROW_W-1:0]};
      sB = {{HI_W{opB[NARROW_W-1]}},  opB[NARROW_W-1:0]};
      uA = {{HI_W{1'b0}}, srcA[NARROW_W-1:0]};
      uB = {{HI_W{1'b0}}, opB[NARROW_W-1:0]};
    end else begin
      sA = srcA;
      sB = opB;
      uA = srcA;
      uB = opB;
    end
    lhsS = ctrl.swap ? sB : sA;
    rhsS = ctrl.swap ? sA : sB;
    lhsU = ctrl.swap ? uB : uA;
    rhsU = ctrl.swap ? uA : uB;
    isEq  = (uA == uB);
    ltRaw = ctrl.selUns ? (lhsU < rhsU) : ($signed(lhsS) < $signed(rhsS));
    relOut  = ctrl.invert ^ (ctrl.selEq ? isEq : ltRaw);
    outcome = ctrl.useBit ? srcA[bitPos] : relOut;
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : gTgt
    assign nextEn[t]  = outcome ? ctrl.wrOnTrue[t]  : ctrl.wrOnFalse[t];
    assign nextVal[t] = outcome ? ctrl.valOnTrue[t] : ctrl.valOnFalse[t];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      tgtWrEn  <= '0;
      tgtVal   <= '0;
    end else begin
      outValid <= ctrl.opValid;
      tgtWrEn  <= ctrl.opValid ? nextEn : '0;
      tgtVal   <= nextVal;
    end
  end

endmodule

// File: rtl/predCmpUnit.sv
module predCmpUnit
  import predCmpPkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 8,
  localparam int POS_W   = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [IMM_W-1:0]   immVal,
  input  logic               useImm,
  input  logic               narrowMode,
  input  logic               bitTest,
  input  logic [POS_W-1:0]   bitPos,
  input  logic [3:0]         relCode,
  input  logic [2:0]         cmpType,
  input  logic               qualPred,
  output logic               outValid,
  output logic               tgt1WrEn,
  output logic               tgt1Val,
  output logic               tgt2WrEn,
  output logic               tgt2Val
);

  ctrlStrobes_t       ctrl;
  logic [NUM_TGT-1:0] tgtWrEn, tgtVal;

  predCmpCtrl ctrl_i (
    .inValid (inValid),
    .bitTest (bitTest),
    .relCode (relCode),
    .cmpType (cmpType),
    .qualPred(qualPred),
    .ctrl    (ctrl)
  );

  predCmpDatapath #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .IMM_W   (IMM_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .srcA      (srcA),
    .srcB      (srcB),
    .immVal    (immVal),
    .useImm    (useImm),
    .narrowMode(narrowMode),
    .bitPos    (bitPos),
    .outValid  (outValid),
    .tgtWrEn   (tgtWrEn),
    .tgtVal    (tgtVal)
  );

  assign tgt1WrEn = tgtWrEn[0];
  assign tgt1Val  = tgtVal[0];
  assign tgt2WrEn = tgtWrEn[1];
  assign tgt2Val  = tgtVal[1];

endmodule

// File: rtl/predCmpChecker.sv
module predCmpChecker #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [DATA_W-1:0]  srcA,
  input logic               bitTest,
  input logic [POS_W-1:0]   bitPos,
  input logic [3:0]         relCode,
  input logic [2:0]         cmpType,
  input logic               qualPred,
  input logic               outValid,
  input logic               tgt1WrEn,
  input logic               tgt1Val,
  input logic               tgt2WrEn,
  input logic               tgt2Val
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && !tgt1WrEn && !tgt2WrEn); // R1
  AST_ILLEGAL_REL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !bitTest && relCode > 4'd9 |=> !tgt1WrEn && !tgt2WrEn); // R6
  AST_QP0_ONLY_UNCOND: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !qualPred && cmpType != 3'd1 |=> !tgt1WrEn && !tgt2WrEn); // R7
  AST_UNCOND_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !qualPred && cmpType == 3'd1 && (bitTest || relCode <= 4'd9)
    |=> tgt1WrEn && tgt2WrEn && !tgt1Val && !tgt2Val); // R8
  AST_NORMAL_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && qualPred && cmpType <= 3'd1 && (bitTest || relCode <= 4'd9)
    |=> tgt1WrEn && tgt2WrEn && (tgt1Val != tgt2Val)); // R7
  AST_BIT_TEST_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && bitTest && qualPred && cmpType == 3'd0
    |=> tgt1Val == $past(srcA[bitPos])); // R5
  AST_SAME_VALUE_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    inValid && qualPred && cmpType >= 3'd2 && cmpType <= 3'd5
    |=> (tgt1WrEn == tgt2WrEn) && (!tgt1WrEn || tgt1Val == tgt2Val)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !outValid && !tgt1WrEn && !tgt2WrEn); // R12

endmodule

bind predCmpUnit predCmpChecker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .srcA    (srcA),
  .bitTest (bitTest),
  .bitPos  (bitPos),
  .relCode (relCode),
  .cmpType (cmpType),
  .qualPred(qualPred),
  .outValid(outValid),
  .tgt1WrEn(tgt1WrEn),
  .tgt1Val (tgt1Val),
  .tgt2WrEn(tgt2WrEn),
  .tgt2Val (tgt2Val)
);

// File: tb/predCmpUnit_tb_top.sv
`timescale 1ns/1ps
module predCmpUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcA = '0, srcB = '0;
  logic [7:0]  immVal = '0;
  logic        useImm = 1'b0, narrowMode = 1'b0, bitTest = 1'b0;
  logic [5:0]  bitPos = '0;
  logic [3:0]  relCode = '0;
  logic [2:0]  cmpType = '0;
  logic        qualPred = 1'b0;
  logic        outValid, tgt1WrEn, tgt1Val, tgt2WrEn, tgt2Val;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  predCmpUnit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .immVal(immVal), .useImm(useImm), .narrowMode(narrowMode),
    .bitTest(bitTest), .bitPos(bitPos), .relCode(relCode),
    .cmpType(cmpType), .qualPred(qualPred), .outValid(outValid),
    .tgt1WrEn(tgt1WrEn), .tgt1Val(tgt1Val), .tgt2WrEn(tgt2WrEn),
    .tgt2Val(tgt2Val)
  );

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got {valid,en1,v1,en2,v2}=%b expected %b", tag, got, exp);
    end
  endtask

  // Returns {legal, outcome}
  function automatic logic [1:0] refOut(input logic [63:0] a, input logic [63:0] b,
      input logic [7:0] imm, input logic ui, input logic nw, input logic bt,
      input logic [5:0] pos, input logic [3:0] rel);
    logic [63:0] bb, ua, ub;
    logic signed [63:0] sa, sb;
    logic o;
    bb = ui ? {{56{imm[7]}}, imm} : b;
    if (nw) begin
      sa = $signed(a[31:0]);  sb = $signed(bb[31:0]);
      ua = {32'b0, a[31:0]};  ub = {32'b0, bb[31:0]};
    end else begin
      sa = a;  sb = bb;  ua = a;  ub = bb;
    end
    if (bt) return {1'b1, a[pos]};
    case (rel)
      4'd0: o = (ua == ub);
      4'd1: o = (ua != ub);
      4'd2: o = (sa <  sb);
      4'd3: o = (sa <= sb);
      4'd4: o = (sa >  sb);
      4'd5: o = (sa >= sb);
      4'd6: o = (ua <  ub);
      4'd7: o = (ua <= ub);
      4'd8: o = (ua >  ub);
      4'd9: o = (ua >= ub);
      default: return 2'b00;
    endcase
    return {1'b1, o};
  endfunction

  // Returns {en1, v1, en2, v2} with values masked by enables
  function automatic logic [3:0] refWr(input logic [2:0] ty, input logic qp,
      input logic o, input logic legal);
    logic [3:0] w;
    w = 4'b0000;
    if (legal) begin
      case (ty)
        3'd0: if (qp) w = {1'b1, o, 1'b1, !o};
        3'd1: w = qp ? {1'b1, o, 1'b1, !o} : 4'b1010;
        3'd2: if (qp && !o) w = 4'b1010;
        3'd3: if (qp && o)  w = 4'b1010;
        3'd4: if (qp && o)  w = 4'b1111;
        3'd5: if (qp && !o) w = 4'b1111;
        3'd6: if (qp && o)  w = 4'b1110;
        3'd7: if (qp && !o) w = 4'b1011;
        default: w = 4'b0000;
      endcase
    end
    return w;
  endfunction

  function automatic string tagFor(input logic legal, input logic bt, input logic [2:0] ty,
      input logic qp, input logic ui, input logic nw);
    if (!legal) return "R6";
    if (bt) return "R5";
    if (ty == 3'd0 && qp) return ui ? "R4" : (nw ? "R3" : "R2");
    case (ty)
      3'd0:       return "R7";
      3'd1:       return qp ? "R7" : "R8";
      3'd2, 3'd3: return "R9";
      3'd4, 3'd5: return "R10";
      default:    return "R11";
    endcase
  endfunction

  function automatic logic [127:0] pattern(input int idx);
    case (idx)
      0: return {64'd5, 64'd5};
      1: return {64'hFFFF_FFFF_FFFF_FFFF, 64'd1};
      2: return {64'd1, 64'hFFFF_FFFF_FFFF_FFFF};
      3: return {64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001};
      4: return {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
      5: return {64'h1234_5678_8000_0000, 64'hABCD_0000_7FFF_FFFF};
      6: return {64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005};
      default: return {64'd3, 64'd7};
    endcase
  endfunction

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [7:0] imm,
      input logic ui, input logic nw, input logic bt, input logic [5:0] pos,
      input logic [3:0] rel, input logic [2:0] ty, input logic qp);
    logic [1:0] r;
    logic [3:0] w;
    logic [4:0] got;
    srcA = a; srcB = b; immVal = imm; useImm = ui; narrowMode = nw;
    bitTest = bt; bitPos = pos; relCode = rel; cmpType = ty; qualPred = qp;
    inValid = 1'b1;
    r = refOut(a, b, imm, ui, nw, bt, pos, rel);
    w = refWr(ty, qp, r[0], r[1]);
    @(posedge clk);
    @(negedge clk);
    got = {outValid, tgt1WrEn, tgt1WrEn & tgt1Val, tgt2WrEn, tgt2WrEn & tgt2Val};
    check(tagFor(r[1], bt, ty, qp, ui, nw), got, {1'b1, w});
  endtask

  initial begin
    logic [127:0] p;
    // R12: reset holds outputs low even with a request present
    inValid = 1'b1; qualPred = 1'b1; cmpType = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", {outValid, tgt1WrEn, 1'b0, tgt2WrEn, 1'b0}, 5'b00000);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {outValid, tgt1WrEn, 1'b0, tgt2WrEn, 1'b0}, 5'b00000);

    // Relation sweep: patterns x width x operand source x relation x rule x qp
    for (int pi = 0; pi < 8; pi++) begin
      p = pattern(pi);
      for (int nw = 0; nw < 2; nw++)
        for (int ui = 0; ui < 2; ui++)
          for (int rel = 0; rel < 16; rel++)
            for (int ty = 0; ty < 8; ty++)
              for (int qp = 0; qp < 2; qp++)
                runOp(p[127:64], p[63:0], p[7:0], ui[0], nw[0], 1'b0, 6'd0,
                      rel[3:0], ty[2:0], qp[0]);
    end

    // R5: bit-test sweep with arbitrary (incl. illegal) relation codes
    for (int pos = 0; pos < 64; pos++)
      for (int ty = 0; ty < 8; ty++)
        runOp(64'hF0E1_D2C3_B4A5_9687, 64'd0, 8'h00, 1'b0, pos[0], 1'b1, pos[5:0],
              pos[3:0] | 4'hA, ty[2:0], 1'b1);

    // R1: idle cycles with live-looking inputs produce nothing
    inValid = 1'b0; qualPred = 1'b0; cmpType = 3'd1; relCode = 4'd0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1", {outValid, tgt1WrEn, 1'b0, tgt2WrEn, 1'b0}, 5'b00000);
    end

    // R1: a single request is reported for exactly one cycle
    runOp(64'd9, 64'd2, 8'd0, 1'b0, 1'b0, 1'b0, 6'd0, 4'd4, 3'd0, 1'b1);
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", {outValid, tgt1WrEn, 1'b0, tgt2WrEn, 1'b0}, 5'b00000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule